// File: doc/BRIEF.md
# Scalar AES Byte Round Step

This unit performs one step of a table-free AES round on a 32-bit datapath. Each operation picks a single byte from the second operand, passes it through the forward or inverse AES S-box, and optionally expands the substituted byte into the contribution that byte makes to one MixColumns (or InvMixColumns) column. The 32-bit word is then rotated left by the byte position and XORed into the first operand. A full round column is built by issuing four operations, one per byte position, and accumulating into the same register.

The operation takes one clock cycle. An operation is offered with `in_valid`. The result, its valid flag and the destination register index are registered together on the next rising edge. The destination index is carried through from the field that named the first source operand. Instruction decode and register file writeback stay outside the block.

Top module: `aes_bs_round`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `out_valid` is 0, `out_result` is 0 and `out_rd` is 0.
- R2: The byte that is processed is `in_rs2[8*in_bs +: 8]`. With `in_bs` = 0 this is bits 7:0, and with `in_bs` = 3 it is bits 31:24.
- R3: Operation codes are 2'b00 encrypt, 2'b01 encrypt-mix, 2'b10 decrypt and 2'b11 decrypt-mix. Bit 1 selects decryption and bit 0 selects the mix form. The encrypt codes substitute the byte with the forward AES S-box, and the decrypt codes use the inverse S-box.
- R4: For codes 2'b00 and 2'b10, the pre-rotation word holds the substituted byte s in bits 7:0 and zero in bits 31:8.
- R5: For code 2'b01, the pre-rotation word from bit 31 down to bit 0 is {3·s, s, s, 2·s}. The products are in GF(2^8) with reduction polynomial 0x11b.
- R6: For code 2'b11, the pre-rotation word from bit 31 down to bit 0 is {0x0b·s, 0x0d·s, 0x09·s, 0x0e·s}, in the same field.
- R7: The pre-rotation word is rotated left by 8·`in_bs` bits. With `in_bs` = 0 the word is left unchanged.
- R8: When `in_valid` is high at a rising edge, `out_result` becomes the rotated word XOR `in_rs1` and `out_valid` is 1 after that edge.
- R9: When `in_valid` is high at a rising edge, `out_rd` becomes the value on `in_rd` after that edge.
- R10: When `in_valid` is low at a rising edge, `out_valid` is 0 after that edge, and `out_result` and `out_rd` keep their previous values whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is offered this cycle |
| in_op | input | 2 | Operation code (see R3) |
| in_bs | input | 2 | Byte position, from instruction bits 31:30 |
| in_rs1 | input | 32 | Accumulator operand |
| in_rs2 | input | 32 | Operand supplying the byte |
| in_rd | input | 5 | Destination index, taken from the first source field |
| out_valid | output | 1 | Result registered this cycle |
| out_result | output | 32 | Accumulated word |
| out_rd | output | 5 | Destination index of the result |

## Verification
Every result appears exactly one rising edge after the edge that accepts its operation. The bench therefore changes inputs on the falling edge and reads `out_result`, `out_valid` and `out_rd` on the next falling edge, half a period after the edge that registered them. The sweep issues one operation per cycle, so each sample belongs to the operation issued one cycle before it. Hold checks apply idle cycles with altered operands and read the outputs at the same falling-edge point, confirming that nothing moved.

// File: rtl/aes_bs_pkg.sv
package aes_bs_pkg;

    localparam int unsigned XLEN   = 32;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NBYTES = XLEN / BYTE_W;
    localparam int unsigned BS_W   = $clog2(NBYTES);
    localparam int unsigned IDX_W  = 5;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [XLEN-1:0]   word_t;

    typedef enum logic [1:0] {
        OP_ENC     = 2'b00,
        OP_ENC_MIX = 2'b01,
        OP_DEC     = 2'b10,
        OP_DEC_MIX = 2'b11
    } bs_op_e;

    typedef struct packed {
        logic              dec;
        logic              mix;
        logic [BS_W-1:0]   pos;
    } step_ctl_t;

    // Multiply by x modulo 0x11b.
    function automatic byte_t gf_xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // Shift-and-add multiply built from xtime stages.
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t run;
        acc = '0;
        run = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ run;
            run = gf_xtime(run);
        end
        return acc;
    endfunction

    // Field inverse as a^254; maps 0 to 0.
    function automatic byte_t gf_inv(input byte_t a);
        byte_t pw;
        byte_t acc;
        pw  = a;
        acc = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            pw  = gf_mul(pw, pw);
            acc = gf_mul(acc, pw);
        end
        return acc;
    endfunction

    function automatic byte_t affine_fwd(input byte_t b);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                 ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction

    function automatic byte_t affine_inv(input byte_t b);
        return {b[6:0], b[7]} ^ {b[4:0], b[7:5]} ^ {b[1:0], b[7:2]} ^ 8'h05;
    endfunction

endpackage

// File: rtl/aes_bs_sbox.sv
module aes_bs_sbox
    import aes_bs_pkg::*;
(
    input  byte_t in_byte,
    input  logic  inverse,
    output byte_t out_byte
);
    byte_t pre_inv;
    byte_t field_inv;

    // One shared inverter: the affine map sits after it going forward
    // and its inverse sits before it going backward.
    always_comb begin
        pre_inv   = inverse ? affine_inv(in_byte) : in_byte;
        field_inv = gf_inv(pre_inv);
        out_byte  = inverse ? field_inv : affine_fwd(field_inv);
    end

    // R3: neither S-box direction has a fixed point
    always_comb begin
        a_r3_no_fixed_point: assert (out_byte != in_byte);
    end
endmodule

// File: rtl/aes_bs_mix.sv
module aes_bs_mix
    import aes_bs_pkg::*;
(
    input  byte_t s,
    input  logic  dec,
    input  logic  mix,
    output word_t col
);
    byte_t m2, m3, m9, mb, md, me;
    byte_t x4, x8;

    always_comb begin
        m2 = gf_xtime(s);
        x4 = gf_xtime(m2);
        x8 = gf_xtime(x4);
        m3 = m2 ^ s;
        m9 = x8 ^ s;
        mb = x8 ^ m2 ^ s;
        md = x8 ^ x4 ^ s;
        me = x8 ^ x4 ^ m2;
        unique case ({dec, mix})
            2'b01:   col = {m3, s, s, m2};
            2'b11:   col = {mb, md, m9, me};
            default: col = {{(XLEN-BYTE_W){1'b0}}, s};
        endcase
    end

    // R5 and R6: relations between the lanes of the expanded column
    always_comb begin
        if (mix && !dec) begin
            a_r5_enc_lane_rel: assert ((col[31:24] ^ col[7:0]) == col[15:8]);
        end
        if (mix && dec) begin
            a_r6_dec_lane_rel: assert ((col[31:24] ^ col[15:8]) == gf_xtime(s));
        end
    end
endmodule

// File: rtl/aes_bs_rot.sv
module aes_bs_rot
    import aes_bs_pkg::*;
(
    input  word_t           word_i,
    input  logic [BS_W-1:0] amt,
    output word_t           word_o
);
    // Each output lane picks a source lane; no wide shifter is formed.
    for (genvar j = 0; j < NBYTES; j++) begin : g_lane
        logic [BS_W-1:0] src;
        assign src = BS_W'(j) - amt;
        assign word_o[BYTE_W*j +: BYTE_W] = word_i[BYTE_W*src +: BYTE_W];
    end

    // R7: rotation keeps the population count
    always_comb begin
        a_r7_popcount_kept: assert ($countones(word_o) == $countones(word_i));
    end
endmodule

// File: rtl/aes_bs_round.sv
module aes_bs_round
    import aes_bs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [BS_W-1:0]  in_bs,
    input  logic [XLEN-1:0]  in_rs1,
    input  logic [XLEN-1:0]  in_rs2,
    input  logic [IDX_W-1:0] in_rd,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_result,
    output logic [IDX_W-1:0] out_rd
);
    step_ctl_t ctl;
    bs_op_e    op_k;
    byte_t     picked;
    byte_t     subst;
    word_t     column;
    word_t     rotated;

    assign op_k     = bs_op_e'(in_op);
    assign ctl.dec  = (op_k == OP_DEC) || (op_k == OP_DEC_MIX);
    assign ctl.mix  = (op_k == OP_ENC_MIX) || (op_k == OP_DEC_MIX);
    assign ctl.pos  = in_bs;
    assign picked   = in_rs2[BYTE_W*ctl.pos +: BYTE_W];

    aes_bs_sbox u_sbox (
        .in_byte  (picked),
        .inverse  (ctl.dec),
        .out_byte (subst)
    );

    aes_bs_mix u_mix (
        .s   (subst),
        .dec (ctl.dec),
        .mix (ctl.mix),
        .col (column)
    );

    aes_bs_rot u_rot (
        .word_i (column),
        .amt    (ctl.pos),
        .word_o (rotated)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_rd     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= rotated ^ in_rs1;
                out_rd     <= in_rd;
            end
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0 && out_rd == '0));

    a_r8_result_due: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r9_rd_carried: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_rd == $past(in_rd)));

    a_r4_single_lane: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op[0]) |=> ($countones(out_result ^ $past(in_rs1)) <= 8));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_rd)));
endmodule

// File: tb/sim_aes_bs_round.sv
`timescale 1ns/1ps
module sim_aes_bs_round;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [1:0]  in_bs = 2'b00;
    logic [31:0] in_rs1 = '0;
    logic [31:0] in_rs2 = '0;
    logic [4:0]  in_rd = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [4:0]  out_rd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int alog [0:255];
    int lg   [0:255];
    logic [7:0] fwd [0:255];
    logic [7:0] inv [0:255];

    always #10 clk = ~clk;

    aes_bs_round u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_bs(in_bs), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rd(in_rd),
        .out_valid(out_valid), .out_result(out_result), .out_rd(out_rd)
    );

    function automatic logic [7:0] mul_t(input logic [7:0] a, input logic [7:0] b);
        if (a == 0 || b == 0) return 8'h00;
        return 8'(alog[(lg[a] + lg[b]) % 255]);
    endfunction

    function automatic logic [31:0] model(input logic [1:0] op, input logic [1:0] bs,
                                          input logic [31:0] r1, input logic [31:0] r2);
        logic [7:0]  b, s;
        logic [31:0] w;
        logic [63:0] d;
        b = 8'(r2 >> (8 * bs));                                     // R2
        s = op[1] ? inv[b] : fwd[b];                                // R3
        case (op)
            2'b01:   w = {mul_t(s, 3), s, s, mul_t(s, 2)};           // R5
            2'b11:   w = {mul_t(s, 8'h0b), mul_t(s, 8'h0d),
                          mul_t(s, 8'h09), mul_t(s, 8'h0e)};         // R6
            default: w = {24'h0, s};                                 // R4
        endcase
        d = {w, w} << (8 * bs);                                      // R7
        return d[63:32] ^ r1;                                        // R8
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        // Independent tables: powers of the generator 3, then the affine map.
        int p;
        p = 1;
        for (int i = 0; i < 255; i++) begin
            alog[i] = p;
            lg[p]   = i;
            p = p ^ ((p << 1) ^ (((p >> 7) & 1) * 'h11b));
            p = p & 'hff;
        end
        for (int a = 0; a < 256; a++) begin
            logic [7:0] iv, o;
            iv = (a == 0) ? 8'h00 : 8'(alog[(255 - lg[a]) % 255]);
            for (int i = 0; i < 8; i++)
                o[i] = iv[i] ^ iv[(i+4)%8] ^ iv[(i+5)%8] ^ iv[(i+6)%8]
                     ^ iv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
            fwd[a] = o;
            inv[o] = 8'(a);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid", {31'b0, out_valid}, 32'h0);
        check("R1 result", out_result, 32'h0);
        check("R1 rd", {27'b0, out_rd}, 32'h0);

        // Sweep every byte value, operation and position, one per cycle.
        for (int v = 0; v < 256; v++) begin
            for (int op = 0; op < 4; op++) begin
                for (int bs = 0; bs < 4; bs++) begin
                    logic [31:0] r1, r2, exp;
                    logic [4:0]  rd;
                    r1 = 32'h9e3779b9 * (v + 1) ^ (op * 32'h01010101) ^ bs;
                    r2 = (32'hc3a5_5a3c ^ (32'h1111_1111 * bs + v * 32'h0001_0203));
                    r2 = (r2 & ~(32'hff << (8 * bs))) | (32'(v) << (8 * bs));
                    rd = 5'(v + op * 7 + bs);
                    in_valid = 1'b1;
                    in_op = 2'(op); in_bs = 2'(bs);
                    in_rs1 = r1; in_rs2 = r2; in_rd = rd;
                    exp = model(2'(op), 2'(bs), r1, r2);
                    @(negedge clk);
                    check($sformatf("R8 op%0d bs%0d v%0d", op, bs, v), out_result, exp);
                    if (v % 64 == 0) begin
                        check("R9 rd", {27'b0, out_rd}, {27'b0, rd});
                        check("R8 valid", {31'b0, out_valid}, 32'h1);
                    end
                end
            end
        end

        // Known points: forward S-box of 0x00 is 0x63, inverse of 0x00 is 0x52.
        in_op = 2'b00; in_bs = 2'd0; in_rs1 = 0; in_rs2 = 0; in_valid = 1'b1;
        @(negedge clk);
        check("R3 fwd 00", out_result, 32'h0000_0063);
        in_op = 2'b10; in_bs = 2'd3; in_rs2 = 32'h00ff_ffff;
        @(negedge clk);
        check("R7 inv 00 bs3", out_result, 32'h5200_0000);

        // Idle cycles with changed operands must not disturb the outputs.
        in_valid = 1'b0;
        in_op = 2'b11; in_bs = 2'd1; in_rs1 = 32'hdead_beef; in_rs2 = 32'h1234_5678; in_rd = 5'd17;
        @(negedge clk);
        check("R10 result", out_result, 32'h5200_0000);
        check("R10 valid", {31'b0, out_valid}, 32'h0);
        in_rs1 = 32'h0bad_f00d;
        @(negedge clk);
        check("R10 result2", out_result, 32'h5200_0000);

        // Reset after activity clears the outputs.
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 re-reset", out_result, 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule